// File: doc/BRIEF.md
# Machine Control Register with Legacy Status-Word Port

This block holds a 32-bit control register that carries machine-wide state. Software reaches it two ways: a full-width port that reads and writes all 32 bits, and a narrow legacy port that sees only the low 16 bits, called the status word. Two bits steer the rest of the chip:
- bit 31 drives the paging-enable output;
- bit 4 drives the coprocessor-protocol output, where 1 selects the 32-bit protocol and 0 selects the 16-bit protocol.

Only bits 31, 4, 3, 2, 1 and 0 are implemented (mask `32'h8000_001F`). Every other bit reads zero.

Bit 4 gets its start-up value from the hardware rather than from software. On the first clock after reset is released, the register samples the active-low coprocessor error input into that bit. A legacy status-word write never alters bit 4, so older software cannot change the protocol choice by accident. A full-width write can set or clear it.

Both ports are plain register-access pins and are not streams. A write strobe is taken on every rising clock edge where it is high, and the port has no back-pressure. Read data is the current register contents, with no added latency. A write therefore shows on the read ports one cycle after its strobe.

Top module: `mcr_ctl`

## Requirements
- R1: While reset is asserted, both read ports, `paging_en` and `proto32` are all zero.
- R2: On the first rising clock edge after reset is released, bit 4 is loaded with the inverse of `cop_err_n`: a low input gives 1 and a high input gives 0. Later changes of `cop_err_n` have no effect.
- R3: A full-width write stores `full_wr_data & 32'h8000_001F`. The stored value is visible on `full_rd_data` in the next cycle, and unimplemented bits always read zero.
- R4: A legacy write (with no full-width write in the same cycle) loads bits 3:0 from `sw_wr_data[3:0]`. Bits 31:16 keep their previous values.
- R5: A legacy write never changes bit 4, whatever the value of `sw_wr_data[4]`.
- R6: A full-width write sets or clears bit 4, and `proto32` always equals the stored bit 4.
- R7: `paging_en` always equals stored bit 31.
- R8: When both write strobes are high in the same cycle, only the full-width write takes effect.
- R9: A full-width write in the sampling cycle of R2 takes priority over the sample for bit 4.
- R10: `sw_rd_data` always equals `full_rd_data[15:0]`, including bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_err_n | input | 1 | Active-low coprocessor error level, sampled once after reset |
| full_wr_en | input | 1 | Full-width write strobe |
| full_wr_data | input | 32 | Full-width write data |
| full_rd_data | output | 32 | Current register value |
| sw_wr_en | input | 1 | Legacy status-word write strobe |
| sw_wr_data | input | 16 | Legacy write data |
| sw_rd_data | output | 16 | Low 16 bits of the register |
| paging_en | output | 1 | Paging enable (bit 31) |
| proto32 | output | 1 | 1 selects the 32-bit coprocessor protocol (bit 4) |

## Verification
The register is read back with no latency, so a wrong bit appears on both read ports one cycle after the write that caused it. A start-up sampling error would instead appear on `proto32` one cycle after reset is released.

The bench sweeps every combination of the six implemented bits through the full-width port. It sweeps every low nibble through the legacy port, with bit 4 and the upper halfword of the write data toggled. The bench covers both error-pin levels at start-up, and write collisions both in normal operation and in the sampling cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned MCR_W    = 32;
  localparam int unsigned SW_W     = 16;
  localparam int unsigned PG_BIT   = 31;
  localparam int unsigned TYPE_BIT = 4;
  localparam logic [MCR_W-1:0] IMPL_MASK = 32'h8000_001F;
endpackage

// File: rtl/mcr_init_sampler.sv
// Marks the single cycle after reset release in which the error level is captured.
module mcr_init_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic err_n,
  output logic smp_en,
  output logic smp_val
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b1;
    else        pending_q <= 1'b0;
  end

  assign smp_en  = pending_q;
  assign smp_val = ~err_n;

  // R2: the sampling window lasts exactly one cycle
  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |=> !pending_q);
endmodule

// File: rtl/mcr_next.sv
// Per-bit next-state selection: full write, then legacy write / sample, then hold.
module mcr_next #(
  parameter int unsigned W        = mcr_pkg::MCR_W,
  parameter int unsigned SWW      = mcr_pkg::SW_W,
  parameter int unsigned TYPE_BIT = mcr_pkg::TYPE_BIT,
  parameter logic [W-1:0] MASK    = mcr_pkg::IMPL_MASK
) (
  input  logic [W-1:0]   cur,
  input  logic           full_en,
  input  logic [W-1:0]   full_d,
  input  logic           sw_en,
  input  logic [SWW-1:0] sw_d,
  input  logic           smp_en,
  input  logic           smp_val,
  output logic [W-1:0]   nxt
);
  localparam logic [SWW-1:0] SW_MASK = MASK[SWW-1:0] & ~(SWW'(1) << TYPE_BIT);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!MASK[i]) begin : g_rsvd
      assign nxt[i] = 1'b0;
    end else if (i == TYPE_BIT) begin : g_type
      assign nxt[i] = full_en ? full_d[i] : (smp_en ? smp_val : cur[i]);
    end else if (i < SWW) begin : g_low
      assign nxt[i] = full_en ? full_d[i] : (sw_en ? sw_d[i] : cur[i]);
    end else begin : g_high
      assign nxt[i] = full_en ? full_d[i] : cur[i];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{full_d & ~MASK, cur & ~MASK, sw_d & ~SW_MASK};
endmodule

// File: rtl/mcr_ctl.sv
module mcr_ctl #(
  parameter int unsigned W        = mcr_pkg::MCR_W,
  parameter int unsigned SWW      = mcr_pkg::SW_W,
  parameter int unsigned PG_BIT   = mcr_pkg::PG_BIT,
  parameter int unsigned TYPE_BIT = mcr_pkg::TYPE_BIT,
  parameter logic [W-1:0] MASK    = mcr_pkg::IMPL_MASK
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cop_err_n,
  input  logic           full_wr_en,
  input  logic [W-1:0]   full_wr_data,
  output logic [W-1:0]   full_rd_data,
  input  logic           sw_wr_en,
  input  logic [SWW-1:0] sw_wr_data,
  output logic [SWW-1:0] sw_rd_data,
  output logic           paging_en,
  output logic           proto32
);
  logic [W-1:0] reg_q, reg_d;
  logic         smp_en, smp_val;

  mcr_init_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .err_n(cop_err_n),
    .smp_en(smp_en), .smp_val(smp_val)
  );

  mcr_next #(.W(W), .SWW(SWW), .TYPE_BIT(TYPE_BIT), .MASK(MASK)) u_next (
    .cur(reg_q), .full_en(full_wr_en), .full_d(full_wr_data),
    .sw_en(sw_wr_en), .sw_d(sw_wr_data),
    .smp_en(smp_en), .smp_val(smp_val), .nxt(reg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign full_rd_data = reg_q;
  assign sw_rd_data   = reg_q[SWW-1:0];
  assign paging_en    = reg_q[PG_BIT];
  assign proto32      = reg_q[TYPE_BIT];

  // R3 / R8: a full write lands masked, regardless of a concurrent legacy write
  assert_full_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr_en |=> full_rd_data == ($past(full_wr_data) & MASK));

  // R4: legacy write leaves the upper half untouched
  assert_sw_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !full_wr_en) |=> $stable(full_rd_data[W-1:SWW]));

  // R5: legacy write never moves the protocol bit outside the sampling cycle
  assert_sw_keeps_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !full_wr_en && !smp_en) |=> $stable(proto32));

  // R2: the sampled level lands in the protocol bit
  assert_init_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !full_wr_en) |=> proto32 == !$past(cop_err_n));

  // R7: paging turns on only through a full write with bit 31 set
  assert_paging_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paging_en) |-> ($past(full_wr_en) && $past(full_wr_data[PG_BIT])));
endmodule

// File: tb/mcr_ctl_test.sv
module mcr_ctl_test;
  localparam logic [31:0] M = 32'h8000_001F;

  logic        clk = 0, rst_n = 0, cop_err_n = 1;
  logic        full_wr_en = 0, sw_wr_en = 0;
  logic [31:0] full_wr_data = '0, full_rd_data;
  logic [15:0] sw_wr_data = '0, sw_rd_data;
  logic        paging_en, proto32;
  logic [31:0] exp;
  int total = 0, bad = 0;
  bit done = 0;

  mcr_ctl uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, want);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    full_wr_en = 0; sw_wr_en = 0;
  endtask

  task automatic check_all(input string req);
    chk(req, full_rd_data, exp);
    chk({req, "/R10"}, {16'h0, sw_rd_data}, {16'h0, exp[15:0]});
    chk({req, "/R7"}, {31'h0, paging_en}, {31'h0, exp[31]});
    chk({req, "/R6"}, {31'h0, proto32}, {31'h0, exp[4]});
  endtask

  task automatic do_reset(input logic err);
    rst_n = 0; cop_err_n = err;
    repeat (2) @(posedge clk); #1;
    exp = '0;
    check_all("R1");
    #4 rst_n = 1;
  endtask

  task automatic full_wr(input logic [31:0] d);
    full_wr_en = 1; full_wr_data = d; step();
    exp = d & M;
  endtask

  task automatic sw_wr(input logic [15:0] d);
    sw_wr_en = 1; sw_wr_data = d; step();
    exp = (exp & ~32'h0000_000F) | {28'h0, d[3:0]};
  endtask

  initial begin
    // R2: low error level selects 32-bit protocol
    do_reset(1'b0);
    step(); exp = 32'h10;
    check_all("R2");
    cop_err_n = 1; step(); step();
    check_all("R2");

    // R2: high error level selects 16-bit protocol
    do_reset(1'b1);
    step(); exp = 32'h0;
    check_all("R2");
    cop_err_n = 0; step();
    check_all("R2");

    // R3/R6/R7: all implemented-bit combinations, reserved noise set
    for (int v = 0; v < 64; v++) begin
      logic [31:0] d;
      d = {v[5], 26'h0, v[4:0]} | (32'h5A5A_A5A0 ^ (v * 32'h0101_0100));
      full_wr(d);
      check_all("R3");
    end

    // R4/R5: legacy sweep from both protocol states
    for (int base = 0; base < 2; base++) begin
      full_wr(base ? 32'h8000_0010 : 32'h0000_0000);
      for (int s = 0; s < 32; s++) begin
        logic [15:0] d;
        d = {11'h5A3 ^ 11'(s), s[4], s[3:0]};
        sw_wr(d);
        check_all("R4");
        chk("R5", {31'h0, proto32}, {31'h0, base[0]});
      end
    end

    // R8: collisions, full write wins
    for (int k = 0; k < 4; k++) begin
      full_wr_en = 1; full_wr_data = (k[0] ? 32'h8000_0005 : 32'h0000_0012);
      sw_wr_en = 1; sw_wr_data = (k[1] ? 16'hFFFF : 16'h000A);
      step();
      exp = (k[0] ? 32'h8000_0005 : 32'h0000_0012);
      check_all("R8");
    end

    // R9: full write in the sampling cycle beats the sample
    do_reset(1'b0);
    full_wr(32'h8000_0003);
    check_all("R9");
    do_reset(1'b1);
    full_wr(32'h0000_0010);
    check_all("R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule